// File: doc/BRIEF.md
# Bit-Masked Control Register Bank

A bank of 32-bit control registers on a single-cycle memory-mapped bus. Each register address carries a fixed attribute that makes it either a plain register or a bit-masked register. A plain register takes the whole write word and returns the whole word on a read.

A bit-masked register holds 16 meaningful bits. A write to it carries its own per-bit enable in bits 31:16 of the write word, and the candidate new values in bits 15:0. Only bits whose enable is set change. Software can therefore set some bits and clear others in one write, without reading the register first and without racing another writer.

The address map, the set of masked registers and the reset value of every register are parameters. A read returns its data one cycle after the request, with a response-valid flag.

Top module: `ctl_reg_bank`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) loads every register with its parameter reset value and clears rsp_valid. A masked register keeps only bits 15:0 of its reset value, and its bits 31:16 are zero.
- R2: A write to a plain register stores all 32 bits of req_wdata. A later read returns all 32 bits.
- R3: On a write to a masked register, stored bit i (0 to 15) takes req_wdata[i] when req_wdata[i+16] is 1, and otherwise keeps its previous value.
- R4: A masked write whose bits 31:16 are all zero leaves the register unchanged, whatever bits 15:0 hold.
- R5: One masked write can set some bits and clear others. For example, mask 0x0003 with data 0x0001 sets bit 0, clears bit 1 and leaves bits 2 to 15 unchanged.
- R6: A read of a masked register returns the stored value in bits 15:0 and zero in bits 31:16.
- R7: A read request (req_valid=1, req_write=0) gives rsp_valid=1 and the read data on rsp_rdata after the next clock edge. After any other cycle, rsp_valid is 0.
- R8: Register i sits at byte address BASE_ADDR + 4*i. A request to any other address is unmapped, and this includes addresses that are not word-aligned. An unmapped write changes no register. An unmapped read returns zero.
- R9: Bit i of MASK_MAP set means register i is masked. This attribute depends only on the address. With the default map, the register at 0x14804 (index 1) is masked.
- R10: A cycle with req_valid=0 changes no register, whatever req_write, req_addr and req_wdata hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write word; for a masked register, bits 31:16 are the enables and bits 15:0 are the values |
| rsp_valid | output | 1 | Read data is valid this cycle |
| rsp_rdata | output | DATA_W | Registered read data |

## Verification
The stored registers are reachable only through reads, so a corrupted merge, a wrong mask bit or a lost write shows up on rsp_rdata at the next read of that address, one cycle after the request. The bench therefore follows writes with reads quickly and keeps a reference copy of the bank. A write that lands on the wrong register, or an upper half that leaks into a masked register, is caught at the next read of either register. It is not caught at the write itself. A fault in the response path, such as a missing or extra rsp_valid or nonzero data for an unmapped address, shows in the cycle right after the request.

// File: rtl/ctl_bank_pkg.sv
package ctl_bank_pkg;

    localparam int unsigned WORD_BYTES = 4;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } bus_op_e;

    function automatic bus_op_e classify_op(input logic valid, input logic write);
        if (!valid) begin
            return OP_IDLE;
        end
        return write ? OP_WRITE : OP_READ;
    endfunction

endpackage

// File: rtl/ctl_addr_decode.sv
module ctl_addr_decode #(
    parameter int unsigned        ADDR_W    = 20,
    parameter int unsigned        NUM_REGS  = 8,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 20'h14800,
    localparam int unsigned       IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel,
    output logic                hit,
    output logic [IDX_W-1:0]    idx
);
    import ctl_bank_pkg::*;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
        localparam logic [ADDR_W-1:0] REG_ADDR = BASE_ADDR + ADDR_W'(WORD_BYTES * g);
        assign sel[g] = (addr == REG_ADDR);
    end

    always_comb begin
        hit = |sel;
        idx = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ctl_reg_slice.sv
module ctl_reg_slice #(
    parameter int unsigned DATA_W = 32,
    parameter bit          MASKED = 1'b0,
    localparam int unsigned HALF  = DATA_W / 2
) (
    input  logic [DATA_W-1:0] cur,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] nxt
);
    if (MASKED) begin : g_masked
        logic [HALF-1:0] bit_en;
        logic [HALF-1:0] merged;
        logic            unused_cur_hi;

        assign unused_cur_hi = ^cur[DATA_W-1:HALF];
        assign bit_en        = wdata[DATA_W-1:HALF];

        always_comb begin
            merged = (cur[HALF-1:0] & ~bit_en) | (wdata[HALF-1:0] & bit_en);
            nxt    = wr_en ? {{(DATA_W-HALF){1'b0}}, merged}
                           : {{(DATA_W-HALF){1'b0}}, cur[HALF-1:0]};
        end
    end else begin : g_plain
        always_comb begin
            nxt = wr_en ? wdata : cur;
        end
    end

endmodule

// File: rtl/ctl_read_mux.sv
module ctl_read_mux #(
    parameter int unsigned          DATA_W   = 32,
    parameter int unsigned          NUM_REGS = 8,
    parameter logic [NUM_REGS-1:0]  MASK_MAP = 8'hA6,
    localparam int unsigned         IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int unsigned         HALF     = DATA_W / 2
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic                            hit,
    input  logic [IDX_W-1:0]                idx,
    output logic [DATA_W-1:0]               rdata
);
    logic [DATA_W-1:0] picked;

    always_comb begin
        picked = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) begin
                picked = regs[i];
                if (MASK_MAP[i]) begin
                    picked[DATA_W-1:HALF] = '0;
                end
            end
        end
        rdata = hit ? picked : '0;
    end

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank #(
    parameter int unsigned                         ADDR_W    = 20,
    parameter int unsigned                         DATA_W    = 32,
    parameter int unsigned                         NUM_REGS  = 8,
    parameter logic [ADDR_W-1:0]                   BASE_ADDR = 20'h14800,
    parameter logic [NUM_REGS-1:0]                 MASK_MAP  = 8'hA6,
    parameter logic [NUM_REGS-1:0][DATA_W-1:0]     RST_VALS  = {
        32'h0000_0000, 32'h1234_5678, 32'hCAFE_0F0F, 32'h0000_8001,
        32'hDEAD_BEEF, 32'hFFFF_00FF, 32'hA5A5_0001, 32'h0000_0000
    }
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    import ctl_bank_pkg::*;

    localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int unsigned HALF  = DATA_W / 2;

    typedef logic [NUM_REGS-1:0][DATA_W-1:0] bank_t;

    typedef struct packed {
        bank_t             regs;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_rdata;
    } bank_state_t;

    function automatic bank_t effective_reset();
        bank_t v;
        for (int i = 0; i < NUM_REGS; i++) begin
            v[i] = RST_VALS[i];
            if (MASK_MAP[i]) begin
                v[i][DATA_W-1:HALF] = '0;
            end
        end
        return v;
    endfunction

    localparam bank_t RST_EFF = effective_reset();

    bank_state_t       state_d, state_q;
    bus_op_e           op;
    logic [NUM_REGS-1:0] sel;
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] mux_rdata;
    bank_t             slice_nxt;
    bank_t             regs_view;

    assign op = classify_op(req_valid, req_write);

    ctl_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .BASE_ADDR(BASE_ADDR)
    ) i_decode (
        .addr(req_addr),
        .sel (sel),
        .hit (hit),
        .idx (idx)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slice
        ctl_reg_slice #(
            .DATA_W(DATA_W),
            .MASKED(MASK_MAP[g])
        ) i_slice (
            .cur  (state_q.regs[g]),
            .wr_en((op == OP_WRITE) && sel[g]),
            .wdata(req_wdata),
            .nxt  (slice_nxt[g])
        );
    end

    ctl_read_mux #(
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS),
        .MASK_MAP(MASK_MAP)
    ) i_rmux (
        .regs (state_q.regs),
        .hit  (hit),
        .idx  (idx),
        .rdata(mux_rdata)
    );

    always_comb begin
        state_d           = state_q;
        state_d.regs      = slice_nxt;
        state_d.rsp_valid = (op == OP_READ);
        if (op == OP_READ) begin
            state_d.rsp_rdata = mux_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.regs      <= RST_EFF;
            state_q.rsp_valid <= 1'b0;
            state_q.rsp_rdata <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign regs_view = state_q.regs;
    assign rsp_valid = state_q.rsp_valid;
    assign rsp_rdata = state_q.rsp_rdata;

endmodule

// File: rtl/ctl_bank_checker.sv
module ctl_bank_checker #(
    parameter int unsigned                     ADDR_W    = 20,
    parameter int unsigned                     DATA_W    = 32,
    parameter int unsigned                     NUM_REGS  = 8,
    parameter logic [ADDR_W-1:0]               BASE_ADDR = 20'h14800,
    parameter logic [NUM_REGS-1:0]             MASK_MAP  = 8'hA6,
    localparam int unsigned                    HALF      = DATA_W / 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            req_valid,
    input  logic                            req_write,
    input  logic [ADDR_W-1:0]               req_addr,
    input  logic [DATA_W-1:0]               req_wdata,
    input  logic                            rsp_valid,
    input  logic [DATA_W-1:0]               rsp_rdata,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);
    logic [NUM_REGS-1:0] at_reg;
    logic                is_read;
    logic                rd_masked;
    logic                rd_unmapped;

    always_comb begin
        at_reg = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            at_reg[i] = (req_addr == BASE_ADDR + ADDR_W'(4 * i));
        end
        is_read     = req_valid && !req_write;
        rd_masked   = is_read && ((at_reg & MASK_MAP) != '0);
        rd_unmapped = is_read && (at_reg == '0);
    end

    p_rsp_after_read_r7: assert property (@(posedge clk) disable iff (rst)
        is_read |=> rsp_valid);

    p_no_rsp_otherwise_r7: assert property (@(posedge clk) disable iff (rst)
        !is_read |=> !rsp_valid);

    p_masked_read_hi_zero_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && $past(rd_masked) |-> (rsp_rdata[DATA_W-1:HALF] == '0));

    p_unmapped_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && $past(rd_unmapped) |-> (rsp_rdata == '0));

    p_idle_holds_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(regs_q));

    p_one_hot_decode_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(at_reg));

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (MASK_MAP[g]) begin : g_m
            p_zero_mask_keeps_r4: assert property (@(posedge clk) disable iff (rst)
                req_valid && req_write && at_reg[g] && (req_wdata[DATA_W-1:HALF] == '0)
                |=> $stable(regs_q[g]));

            p_enabled_bits_take_r3: assert property (@(posedge clk) disable iff (rst)
                req_valid && req_write && at_reg[g]
                |=> ((regs_q[g][HALF-1:0] ^ $past(req_wdata[HALF-1:0]))
                     & $past(req_wdata[DATA_W-1:HALF])) == '0);

            p_disabled_bits_keep_r3: assert property (@(posedge clk) disable iff (rst)
                req_valid && req_write && at_reg[g]
                |=> ((regs_q[g][HALF-1:0] ^ $past(regs_q[g][HALF-1:0]))
                     & ~$past(req_wdata[DATA_W-1:HALF])) == '0);

            p_masked_hi_stays_zero_r9: assert property (@(posedge clk) disable iff (rst)
                regs_q[g][DATA_W-1:HALF] == '0);
        end else begin : g_p
            p_plain_full_word_r2: assert property (@(posedge clk) disable iff (rst)
                req_valid && req_write && at_reg[g]
                |=> regs_q[g] == $past(req_wdata));
        end
    end

endmodule

bind ctl_reg_bank ctl_bank_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .BASE_ADDR(BASE_ADDR),
    .MASK_MAP (MASK_MAP)
) i_ctl_bank_checker (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .regs_q   (regs_view)
);

// File: tb/test_ctl_reg_bank.sv
module test_ctl_reg_bank;

    localparam int          CLK_PERIOD = 10;
    localparam int          AW   = 20;
    localparam int          DW   = 32;
    localparam int          NR   = 8;
    localparam logic [19:0] BASE = 20'h14800;
    localparam logic [7:0]  MMAP = 8'hA6;
    localparam logic [7:0][31:0] RVALS = {
        32'h0000_0000, 32'h1234_5678, 32'hCAFE_0F0F, 32'h0000_8001,
        32'hDEAD_BEEF, 32'hFFFF_00FF, 32'hA5A5_0001, 32'h0000_0000
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;
    logic [31:0] model [NR];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ctl_reg_bank #(
        .ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NR),
        .BASE_ADDR(BASE), .MASK_MAP(MMAP), .RST_VALS(RVALS)
    ) i_ctl_reg_bank (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    function automatic int addr_index(input logic [19:0] a);
        for (int i = 0; i < NR; i++) begin
            if (a == BASE + 20'(4 * i)) return i;
        end
        return -1;
    endfunction

    function automatic logic [31:0] expect_write(input int i, input logic [31:0] old,
                                                 input logic [31:0] wd);
        logic [31:0] r;
        if (!MMAP[i]) return wd;
        r = 32'h0;
        for (int b = 0; b < 16; b++) begin
            r[b] = wd[b + 16] ? wd[b] : old[b];
        end
        return r;
    endfunction

    function automatic logic [31:0] reset_view(input int i);
        return MMAP[i] ? {16'h0, RVALS[i][15:0]} : RVALS[i];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [19:0] a, input logic [31:0] d);
        int i;
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        i = addr_index(a);
        if (i >= 0) model[i] = expect_write(i, model[i], d);
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [19:0] a, input string req);
        int i;
        logic [31:0] e;
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = $urandom;
        i = addr_index(a);
        e = (i >= 0) ? model[i] : 32'h0;
        @(negedge clk);
        check({req, " rsp_valid"}, 32'(rsp_valid), 32'h1);
        check({req, " rdata"}, rsp_rdata, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NR; i++) model[i] = reset_view(i);
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", 32'(rsp_valid), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R7 idle no rsp", 32'(rsp_valid), 32'h0);

        for (int i = 0; i < NR; i++) bus_read(BASE + 20'(4 * i), "R1 reset value");

        bus_write(BASE + 20'h4, 32'h0003_0001);
        bus_read(BASE + 20'h4, "R5 R9 set and clear at 0x14804");
        bus_write(BASE + 20'h4, 32'h0000_FFFF);
        bus_read(BASE + 20'h4, "R4 zero mask");
        bus_write(BASE + 20'h8, 32'hF0F0_ABCD);
        bus_read(BASE + 20'h8, "R3 partial mask");
        bus_write(BASE + 20'h8, 32'hFFFF_1234);
        bus_read(BASE + 20'h8, "R6 full mask upper reads zero");
        bus_write(BASE + 20'h0, 32'h89AB_CDEF);
        check("R7 no rsp after write", 32'(rsp_valid), 32'h0);
        bus_read(BASE + 20'h0, "R2 plain full word");

        req_valid = 1'b0; req_write = 1'b1; req_addr = BASE; req_wdata = 32'h5555_5555;
        @(negedge clk);
        check("R10 no rsp when idle", 32'(rsp_valid), 32'h0);
        bus_read(BASE, "R10 idle write ignored");

        bus_write(BASE + 20'h2, 32'hFFFF_FFFF);
        bus_write(BASE + 20'h20, 32'hFFFF_FFFF);
        for (int i = 0; i < NR; i++) bus_read(BASE + 20'(4 * i), "R8 unmapped write ignored");
        bus_read(BASE + 20'h2, "R8 misaligned read zero");
        bus_read(BASE + 20'h20, "R8 past end read zero");

        for (int n = 0; n < 600; n++) begin
            int          k;
            logic [19:0] a;
            logic [31:0] d;
            k = $urandom_range(0, 9);
            if (k < 8) a = BASE + 20'(4 * $urandom_range(0, NR - 1));
            else if (k == 8) a = BASE + 20'(4 * $urandom_range(0, NR - 1) + $urandom_range(1, 3));
            else a = 20'($urandom);
            d = $urandom;
            if ($urandom_range(0, 4) == 0) d[31:16] = 16'h0;
            if ($urandom_range(0, 1) == 0) bus_write(a, d);
            else bus_read(a, "R3 R4 R6 R8 random");
        end
        for (int i = 0; i < NR; i++) bus_read(BASE + 20'(4 * i), "R2 R3 final sweep");

        req_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule